// File: doc/BRIEF.md
# Colored-Button Code Lock Detector

The block watches a start button and three colored buttons (red, blue, green), along with a line that is high whenever any colored button is held. It pulses its unlock output only after a start press followed by the color presses red, blue, green and red, in that order. Every color press must be exclusive: the expected color is high and the other two are low. The inputs are assumed to be synchronized already and reduced to single-cycle presses before they reach the block.

A decoder reduces the four button lines to one press class: none, a single color, or invalid. A Moore state machine walks through six states: idle, armed, three partial-code states, and open. Unlock comes only from the open state. It goes high in the cycle that follows the clock edge that samples the final red press. Any press that does not match sends the machine back to idle. Cycles with no colored press leave the machine where it is, so pauses between presses do not break an entry.

Top module: `color_code_lock`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the machine is idle and unlock_o is 0.
- R2: In the idle state, only start_i = 1 at a clock edge leaves idle. Color presses made while idle neither open the lock nor count toward the code.
- R3: The sequence start, red, blue, green, red raises unlock_o = 1 in the cycle after the edge that samples the final red press. Each color press must have any_i = 1, its own color line at 1 and the other two color lines at 0.
- R4: In any code state, a cycle with any_i = 0 keeps the state, whatever red_i, blue_i, green_i and start_i are.
- R5: In a code state, a cycle with any_i = 1 and two or more color lines high returns the machine to idle.
- R6: In a code state, a cycle with any_i = 1 and either a single color other than the expected one, or no color line high, returns the machine to idle.
- R7: unlock_o is high for exactly one cycle. The machine then goes to idle whatever the inputs are.
- R8: start_i has no effect once the machine has left the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start button press |
| red_i | input | 1 | Red button line |
| blue_i | input | 1 | Blue button line |
| green_i | input | 1 | Green button line |
| any_i | input | 1 | High when any colored button is pressed |
| unlock_o | output | 1 | Unlock pulse |

## Verification
The transition that is hardest to reach is an invalid press (two colors at once, or any_i with no color) landing on each of the four code states in turn. That state is internal, so the bench first reaches it with a valid prefix of the code and only then applies the invalid press. It then plays the remaining colors without a new start. The lock must stay shut, which shows from the ports that the machine really went back to idle. Idle gaps, color lines held while any_i is low, and start presses in the middle of an entry are mixed into otherwise valid entries, and those entries must still open the lock.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned CODE_LEN = 4;

  typedef enum logic [2:0] {
    PR_NONE  = 3'd0,
    PR_RED   = 3'd1,
    PR_BLUE  = 3'd2,
    PR_GREEN = 3'd3,
    PR_BAD   = 3'd4
  } press_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GOT1  = 3'd2,
    ST_GOT2  = 3'd3,
    ST_GOT3  = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_e;

  // expected press in each code state
  function automatic press_e want_press(lock_state_e st);
    case (st)
      ST_ARMED: want_press = PR_RED;
      ST_GOT1:  want_press = PR_BLUE;
      ST_GOT2:  want_press = PR_GREEN;
      ST_GOT3:  want_press = PR_RED;
      default:  want_press = PR_BAD;
    endcase
  endfunction

  function automatic lock_state_e step_state(lock_state_e st);
    case (st)
      ST_ARMED: step_state = ST_GOT1;
      ST_GOT1:  step_state = ST_GOT2;
      ST_GOT2:  step_state = ST_GOT3;
      ST_GOT3:  step_state = ST_OPEN;
      default:  step_state = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/lock_press_decode.sv
module lock_press_decode
  import lock_pkg::*;
(
  input  logic   any_i,
  input  logic   red_i,
  input  logic   blue_i,
  input  logic   green_i,
  output press_e press_o
);
  logic [2:0] col;
  assign col = {green_i, blue_i, red_i};

  always_comb begin
    if (!any_i)               press_o = PR_NONE;
    else if (col == 3'b001)   press_o = PR_RED;
    else if (col == 3'b010)   press_o = PR_BLUE;
    else if (col == 3'b100)   press_o = PR_GREEN;
    else                      press_o = PR_BAD;
  end

  // R5: simultaneous colors never decode as a single valid color
  always_comb begin
    if ($countones(col) > 1)
      a_r5_multi_is_bad: assert (press_o == PR_BAD || press_o == PR_NONE);
  end
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
  import lock_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  press_e press_i,
  output logic   unlock_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ARMED;
      ST_OPEN:  state_d = ST_IDLE;
      ST_ARMED, ST_GOT1, ST_GOT2, ST_GOT3: begin
        if (press_i == PR_NONE)                  state_d = state_q;
        else if (press_i == want_press(state_q)) state_d = step_state(state_q);
        else                                     state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign unlock_o = (state_q == ST_OPEN);

  logic in_code;
  assign in_code = (state_q == ST_ARMED) || (state_q == ST_GOT1) ||
                   (state_q == ST_GOT2)  || (state_q == ST_GOT3);

  a_r2_idle_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);

  a_r4_no_press_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_code && press_i == PR_NONE) |=> $stable(state_q));

  a_r6_bad_press_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_code && press_i == PR_BAD) |=> state_q == ST_IDLE);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> !unlock_o);

  a_r3_open_after_red: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> $past(press_i == PR_RED));
endmodule

// File: rtl/color_code_lock.sv
module color_code_lock
  import lock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic red_i,
  input  logic blue_i,
  input  logic green_i,
  input  logic any_i,
  output logic unlock_o
);
  press_e press;

  lock_press_decode u_decode (
    .any_i   (any_i),
    .red_i   (red_i),
    .blue_i  (blue_i),
    .green_i (green_i),
    .press_o (press)
  );

  lock_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .press_i  (press),
    .unlock_o (unlock_o)
  );
endmodule

// File: tb/color_code_lock_bench.sv
module color_code_lock_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, red_i = 1'b0, blue_i = 1'b0, green_i = 1'b0, any_i = 1'b0;
  logic unlock_o;

  int n_chk = 0;
  int n_bad = 0;
  bit    q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  color_code_lock u_color_code_lock (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .red_i(red_i),
    .blue_i(blue_i), .green_i(green_i), .any_i(any_i), .unlock_o(unlock_o)
  );

  // monitor: compares the output after each edge with the queued expectation
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      bit e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (unlock_o !== e) begin
        n_bad++;
        $display("FAIL %s: unlock_o=%b expected %b", t, unlock_o, e);
      end
    end
  end

  task automatic drive(input logic s, input logic r, input logic b, input logic g,
                       input logic a, input bit exp_u, input string tag);
    @(negedge clk);
    start_i = s; red_i = r; blue_i = b; green_i = g; any_i = a;
    q_exp.push_back(exp_u);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input bit e, input string tag);  drive(0,0,0,0,0,e,tag); endtask
  task automatic st(input string tag);                 drive(1,0,0,0,0,0,tag); endtask
  task automatic red(input bit e, input string tag);   drive(0,1,0,0,1,e,tag); endtask
  task automatic blu(input string tag);                drive(0,0,1,0,1,0,tag); endtask
  task automatic grn(input string tag);                drive(0,0,0,1,1,0,tag); endtask

  // plays blue, green, red with no new start: must stay locked
  task automatic tail_locked(input string tag);
    blu(tag); grn(tag); red(0, tag); idle(0, tag);
  endtask

  task automatic prefix(input int k, input string tag);
    st(tag);
    if (k > 0) red(0, tag);
    if (k > 1) blu(tag);
    if (k > 2) grn(tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #12;
    n_chk++;
    if (unlock_o !== 1'b0) begin n_bad++; $display("FAIL R1: unlock_o=%b expected 0", unlock_o); end
    @(negedge clk); rst_ni = 1'b1;
    idle(0, "R1");

    // R3: clean entry
    st("R3"); red(0,"R3"); blu("R3"); grn("R3"); red(1,"R3"); idle(0,"R7");

    // R4: idle gaps and color lines with any_i low
    st("R4"); idle(0,"R4"); idle(0,"R4"); red(0,"R4"); drive(0,0,1,1,0,0,"R4");
    blu("R4"); idle(0,"R4"); grn("R4"); idle(0,"R4"); red(1,"R4"); idle(0,"R4");

    // R8: start in mid-entry is ignored
    st("R8"); red(0,"R8"); st("R8"); blu("R8"); drive(1,0,0,0,0,0,"R8");
    grn("R8"); red(1,"R8"); idle(0,"R8");

    // R2: colors while idle do nothing
    red(0,"R2"); blu("R2"); grn("R2"); red(0,"R2"); idle(0,"R2");

    // R5: red+blue together at every code step
    for (int k = 0; k < 4; k++) begin
      prefix(k, "R5");
      drive(0,1,1,0,1,0,"R5");
      if (k < 1) red(0,"R5");
      tail_locked("R5");
    end
    // R5: all three colors at once
    prefix(2, "R5"); drive(0,1,1,1,1,0,"R5"); grn("R5"); red(0,"R5"); idle(0,"R5");

    // R6: wrong single color mid-entry
    prefix(1, "R6"); grn("R6"); tail_locked("R6");
    prefix(3, "R6"); blu("R6"); red(0,"R6"); idle(0,"R6");
    // R6: any_i high with no color
    prefix(2, "R6"); drive(0,0,0,0,1,0,"R6"); grn("R6"); red(0,"R6"); idle(0,"R6");

    // R7: after open, return to idle regardless of input
    st("R7"); red(0,"R7"); blu("R7"); grn("R7"); red(1,"R7");
    drive(1,1,0,0,1,0,"R7"); red(0,"R7"); blu("R7"); grn("R7"); red(0,"R7"); idle(0,"R7");

    // R1: reset in mid-entry
    prefix(3, "R1");
    drain();
    @(negedge clk); rst_ni = 1'b0;
    #1;
    n_chk++;
    if (unlock_o !== 1'b0) begin n_bad++; $display("FAIL R1: unlock_o=%b expected 0", unlock_o); end
    @(negedge clk); rst_ni = 1'b1;
    red(0,"R1"); idle(0,"R1");

    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule